// File: doc/BRIEF.md
# Double-Buffered 3x4 Colour Matrix

This block converts one pixel per clock from one colour space to another. Each of the three output components is a weighted sum of the three input components plus a per-row offset, rounded to nearest and clamped to the unsigned output range. Weights are signed S2.13 fixed point, so 0x2000 is 1.0. Input components are unsigned 8.4 fixed point. Output components are 12-bit unsigned on the same scale, so a unit matrix reproduces the input exactly.

Two programmable coefficient banks sit beside two constant matrices, one for BT.601 and one for BT.709. Software loads the bank that is not in use through a word-wide write port, then selects it with a mode code. The new choice takes hold only at the next frame-start strobe. At that strobe the chosen matrix is copied into an active set. Writes into any bank therefore never disturb pixels already flowing.

Mode control is a five-state machine: ST_BYPASS, ST_FIX601, ST_FIX709, ST_BANK_A and ST_BANK_B. Its only transition fires on a frame-start strobe and moves to the state decoded from `mode_sel`, which may be the current state. Without a strobe every state holds.

Top module: `csc_matrix3x4`

## Requirements
- R1: While reset is low and after it rises, `pix_valid_out` is 0 and `pix_out` is 0. The state is ST_BYPASS and both banks hold all-zero coefficients.
- R2: A write with `wr_en`=1 selects the bank with `wr_bank` (0 = bank A, 1 = bank B). It selects the coefficient pair with `wr_word`: word w holds coefficient 2w in bits [15:0] and coefficient 2w+1 in bits [31:16]. Coefficient k is row k/4, column k%4, and column 3 is the row offset. Words 6 and 7 change nothing.
- R3: A write changes only the addressed pair of the addressed bank.
- R4: Output row r is floor((x0*c[r][0] + x1*c[r][1] + x2*c[r][2] + c[r][3]*8192 + 4096) / 8192), with all values signed. Component k of `pix_in` and `pix_out` sits at bits [12k+11:12k].
- R5: The mode and the coefficients of the selected source are captured only when `frame_start`=1. Bank writes and changes of `mode_sel` have no effect on output until the next strobe. A pixel presented in the strobe cycle itself still uses the previous set.
- R6: The mode codes are 0 bypass, 2 BT.601, 3 BT.709, 4 bank A and 5 bank B. Codes 1, 6 and 7 act as bypass.
- R7: Each pixel appears on `pix_valid_out` exactly three cycles after it is presented with `pix_valid_in`. Pixels may arrive every cycle, and no valid output appears without a matching input.
- R8: Any row result below 0 outputs 0, and any result above 4095 outputs 4095.
- R9: The fixed matrices map (Y, Cb, Cr) to (R, G, B) and cannot be written. In signed decimal, BT.601 rows are {8192,0,11485,-2871}, {8192,-2819,-5850,2167} and {8192,14516,0,-3629}. BT.709 rows are {8192,0,12901,-3225}, {8192,-1535,-3835,1342} and {8192,15201,0,-3800}.
- R10: Bypass returns each input component unchanged, with the same three-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Coefficient write strobe |
| wr_bank | input | 1 | Target bank, 0 = A, 1 = B |
| wr_word | input | 3 | Coefficient pair index, 0 to 5 |
| wr_data | input | 32 | Two packed S2.13 coefficients |
| frame_start | input | 1 | Frame-start strobe that applies the mode |
| mode_sel | input | 3 | Requested mode code |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_in | input | 36 | Three unsigned 8.4 components |
| pix_valid_out | output | 1 | Output pixel valid |
| pix_out | output | 36 | Three clamped 12-bit components |

## Verification
Several corner cases are targeted directly.

- **Write to the active bank.** The bench writes into the bank that is active and expects the old result until a strobe. A design that reads banks live would change output mid-frame.
- **Pixel in the strobe cycle.** A pixel arriving with the strobe must use the old set. A design whose pipeline reads the new set would mix matrices.
- **Half-LSB rounding.** A gain of 0.5 on odd inputs shows whether results round half up or truncate.
- **Clamping.** Large gains and negative offsets show whether both limits saturate or wrap.
- **Unused words and codes.** Writes to words 6 and 7 and the unused mode codes expose an address that wraps into real coefficients, and a decoder that falls into a bank.
- **Back-to-back pixels.** A stream of consecutive pixels exposes a pipeline that stalls or drops data.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int NCH     = 3;
    localparam int NCOEF   = NCH * (NCH + 1);
    localparam int NWORD   = NCOEF / 2;
    localparam int WORD_AW = $clog2(NWORD + 2);
    localparam int COEF_W  = 16;
    localparam int FRAC    = 13;

    localparam logic [2:0] MODE_BYPASS = 3'd0;
    localparam logic [2:0] MODE_601    = 3'd2;
    localparam logic [2:0] MODE_709    = 3'd3;
    localparam logic [2:0] MODE_BANK_A = 3'd4;
    localparam logic [2:0] MODE_BANK_B = 3'd5;

    typedef logic [NCOEF-1:0][COEF_W-1:0] coef_set_t;

    typedef enum logic [2:0] {
        ST_BYPASS,
        ST_FIX601,
        ST_FIX709,
        ST_BANK_A,
        ST_BANK_B
    } mode_state_e;

    function automatic coef_set_t set_identity();
        coef_set_t s = '0;
        for (int r = 0; r < NCH; r++) s[r*(NCH+1)+r] = COEF_W'(1 << FRAC);
        return s;
    endfunction

    function automatic coef_set_t set_601();
        coef_set_t s;
        s[0] = 16'h2000; s[1]  = 16'h0000; s[2]  = 16'h2CDD; s[3]  = 16'hF4C9;
        s[4] = 16'h2000; s[5]  = 16'hF4FD; s[6]  = 16'hE926; s[7]  = 16'h0877;
        s[8] = 16'h2000; s[9]  = 16'h38B4; s[10] = 16'h0000; s[11] = 16'hF1D3;
        return s;
    endfunction

    function automatic coef_set_t set_709();
        coef_set_t s;
        s[0] = 16'h2000; s[1]  = 16'h0000; s[2]  = 16'h3265; s[3]  = 16'hF367;
        s[4] = 16'h2000; s[5]  = 16'hFA01; s[6]  = 16'hF105; s[7]  = 16'h053E;
        s[8] = 16'h2000; s[9]  = 16'h3B61; s[10] = 16'h0000; s[11] = 16'hF128;
        return s;
    endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_bank,
    input  logic [WORD_AW-1:0] wr_word,
    input  logic [31:0]        wr_data,
    output coef_set_t          bank_a,
    output coef_set_t          bank_b
);
    logic in_range;
    logic hit_a;
    logic hit_b;

    assign in_range = (int'(wr_word) < NWORD);
    assign hit_a    = wr_en && !wr_bank && in_range;
    assign hit_b    = wr_en &&  wr_bank && in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_a <= '0;
            bank_b <= '0;
        end else begin
            for (int w = 0; w < NWORD; w++) begin
                if (hit_a && int'(wr_word) == w) begin
                    bank_a[2*w]   <= wr_data[15:0];
                    bank_a[2*w+1] <= wr_data[31:16];
                end
                if (hit_b && int'(wr_word) == w) begin
                    bank_b[2*w]   <= wr_data[15:0];
                    bank_b[2*w+1] <= wr_data[31:16];
                end
            end
        end
    end

    // R3: a bank with no write aimed at it keeps its contents
    p_bank_a_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_bank) |=> $stable(bank_a));
    p_bank_b_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_bank) |=> $stable(bank_b));
endmodule

// File: rtl/csc_mode_ctrl.sv
module csc_mode_ctrl
    import csc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  logic [2:0] mode_sel,
    input  coef_set_t bank_a,
    input  coef_set_t bank_b,
    output coef_set_t active
);
    mode_state_e state_q;
    mode_state_e state_d;
    coef_set_t   chosen;

    always_comb begin
        unique case (mode_sel)
            MODE_601:    state_d = ST_FIX601;
            MODE_709:    state_d = ST_FIX709;
            MODE_BANK_A: state_d = ST_BANK_A;
            MODE_BANK_B: state_d = ST_BANK_B;
            default:     state_d = ST_BYPASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           state_q <= ST_BYPASS;
        else if (frame_start) state_q <= state_d;
    end

    always_comb begin
        unique case (state_d)
            ST_FIX601: chosen = set_601();
            ST_FIX709: chosen = set_709();
            ST_BANK_A: chosen = bank_a;
            ST_BANK_B: chosen = bank_b;
            default:   chosen = set_identity();
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           active <= set_identity();
        else if (frame_start) active <= chosen;
    end

    // R5: mode and coefficient set move only on a frame-start strobe
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(state_q));
    p_set_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active));
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
    import csc_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  coef_set_t            coef,
    input  logic                 vld_in,
    input  logic [NCH*IN_W-1:0]  pix_in,
    output logic                 vld_out,
    output logic [NCH*OUT_W-1:0] pix_out
);
    localparam int PROD_W = IN_W + 1 + COEF_W;
    localparam int ACC_W  = PROD_W + 3;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << OUT_W) - 1);

    logic [2:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[1:0], vld_in};
    end
    assign vld_out = vld_q[2];

    for (genvar r = 0; r < NCH; r++) begin : g_row
        logic signed [PROD_W-1:0] prod_q [NCH];
        logic signed [COEF_W-1:0] off_q;
        logic signed [ACC_W-1:0]  sum_d;
        logic signed [ACC_W-1:0]  sum_q;
        logic signed [ACC_W-1:0]  shifted;
        logic [OUT_W-1:0]         res_d;
        logic [OUT_W-1:0]         res_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int j = 0; j < NCH; j++) prod_q[j] <= '0;
                off_q <= '0;
            end else begin
                for (int j = 0; j < NCH; j++)
                    prod_q[j] <= $signed({1'b0, pix_in[j*IN_W +: IN_W]})
                               * $signed(coef[r*(NCH+1)+j]);
                off_q <= $signed(coef[r*(NCH+1)+NCH]);
            end
        end

        always_comb begin
            sum_d = HALF + (ACC_W'(off_q) <<< FRAC);
            for (int j = 0; j < NCH; j++) sum_d = sum_d + ACC_W'(prod_q[j]);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sum_q <= '0;
            else        sum_q <= sum_d;
        end

        always_comb begin
            shifted = sum_q >>> FRAC;
            if (shifted < 0)         res_d = '0;
            else if (shifted > MAXV) res_d = '1;
            else                     res_d = shifted[OUT_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        assign pix_out[r*OUT_W +: OUT_W] = res_q;
    end

    // R7: fixed three-cycle latency, and no output without an input
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_in |-> ##3 vld_out);
    p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_out |-> $past(vld_in, 3));
endmodule

// File: rtl/csc_matrix3x4.sv
module csc_matrix3x4
    import csc_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_bank,
    input  logic [WORD_AW-1:0]   wr_word,
    input  logic [31:0]          wr_data,
    input  logic                 frame_start,
    input  logic [2:0]           mode_sel,
    input  logic                 pix_valid_in,
    input  logic [NCH*IN_W-1:0]  pix_in,
    output logic                 pix_valid_out,
    output logic [NCH*OUT_W-1:0] pix_out
);
    coef_set_t bank_a;
    coef_set_t bank_b;
    coef_set_t active;

    csc_coef_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .bank_a  (bank_a),
        .bank_b  (bank_b)
    );

    csc_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .mode_sel    (mode_sel),
        .bank_a      (bank_a),
        .bank_b      (bank_b),
        .active      (active)
    );

    csc_datapath #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .coef    (active),
        .vld_in  (pix_valid_in),
        .pix_in  (pix_in),
        .vld_out (pix_valid_out),
        .pix_out (pix_out)
    );
endmodule

// File: tb/tb_csc_matrix3x4.sv
module tb_csc_matrix3x4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [2:0]  wr_word = '0;
    logic [31:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic        pix_valid_in = 1'b0;
    logic [35:0] pix_in = '0;
    logic        pix_valid_out;
    logic [35:0] pix_out;

    int tests = 0;
    int fails = 0;

    int set_zero[12] = '{0,0,0,0, 0,0,0,0, 0,0,0,0};
    int set_id[12]   = '{8192,0,0,0, 0,8192,0,0, 0,0,8192,0};
    int set601[12]   = '{8192,0,11485,-2871, 8192,-2819,-5850,2167, 8192,14516,0,-3629};
    int set709[12]   = '{8192,0,12901,-3225, 8192,-1535,-3835,1342, 8192,15201,0,-3800};
    int setA[12]     = '{4096,2048,2048,100, -4096,8192,0,0, 16384,-8192,1024,-50};
    int setB[12]     = '{32767,0,0,0, 0,0,-8192,0, 4096,0,0,0};

    // stimulus vectors: {mode, x0, x1, x2}
    localparam logic [38:0] VECS [11] = '{
        {3'd0, 12'd100,  12'd2000, 12'd4095},
        {3'd4, 12'd1000, 12'd400,  12'd3000},
        {3'd4, 12'd0,    12'd0,    12'd0},
        {3'd5, 12'd1,    12'd3000, 12'd3},
        {3'd5, 12'd4095, 12'd0,    12'd3},
        {3'd2, 12'd2048, 12'd2048, 12'd2048},
        {3'd2, 12'd3000, 12'd1000, 12'd3500},
        {3'd3, 12'd1600, 12'd2800, 12'd900},
        {3'd3, 12'd4095, 12'd4095, 12'd4095},
        {3'd6, 12'd77,   12'd88,   12'd99},
        {3'd1, 12'd5,    12'd6,    12'd7}
    };

    csc_matrix3x4 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_word(wr_word), .wr_data(wr_data), .frame_start(frame_start),
        .mode_sel(mode_sel), .pix_valid_in(pix_valid_in), .pix_in(pix_in),
        .pix_valid_out(pix_valid_out), .pix_out(pix_out)
    );

    always #5 clk = ~clk;

    function automatic logic [35:0] model(input int c[12], input int x0, input int x1, input int x2);
        logic [35:0] res;
        int acc;
        int q;
        res = '0;
        for (int r = 0; r < 3; r++) begin
            acc = c[r*4]*x0 + c[r*4+1]*x1 + c[r*4+2]*x2 + c[r*4+3]*8192 + 4096;
            q = acc >>> 13;
            if (q < 0) q = 0;
            else if (q > 4095) q = 4095;
            res[r*12 +: 12] = 12'(q);
        end
        return res;
    endfunction

    function automatic logic [35:0] model_mode(input int m, input int x0, input int x1, input int x2);
        case (m)
            2:       return model(set601, x0, x1, x2);
            3:       return model(set709, x0, x1, x2);
            4:       return model(setA, x0, x1, x2);
            5:       return model(setB, x0, x1, x2);
            default: return model(set_id, x0, x1, x2);
        endcase
    endfunction

    task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic bank, input int w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_word = 3'(w); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_bank(input logic bank, input int c[12]);
        for (int w = 0; w < 6; w++)
            write_word(bank, w, {16'(c[2*w+1]), 16'(c[2*w])});
    endtask

    task automatic apply_mode(input int m);
        @(negedge clk);
        mode_sel = 3'(m); frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic push_check(input string tag, input int x0, input int x1, input int x2,
                              input logic [35:0] exp);
        @(negedge clk);
        pix_valid_in = 1'b1; pix_in = {12'(x2), 12'(x1), 12'(x0)};
        @(negedge clk);
        pix_valid_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tag, {pix_valid_out, pix_out}, {1'b1, exp});
    endtask

    initial begin
        #2_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {pix_valid_out, pix_out}, 37'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", {pix_valid_out, pix_out}, 37'd0);
        push_check("R1 bypass after reset", 123, 456, 789, model(set_id, 123, 456, 789));
        apply_mode(4);
        push_check("R1 bank A zero after reset", 3000, 3000, 3000, model(set_zero, 3000, 3000, 3000));

        // R2: load both banks through the write port
        load_bank(1'b0, setA);
        load_bank(1'b1, setB);

        // table walk: R4 R6 R8 R9 R10
        for (int i = 0; i < 11; i++) begin
            int m;
            int a;
            int b;
            int c;
            m = int'(VECS[i][38:36]);
            a = int'(VECS[i][35:24]);
            b = int'(VECS[i][23:12]);
            c = int'(VECS[i][11:0]);
            apply_mode(m);
            push_check($sformatf("R4 R6 R8 R9 R10 vector %0d mode %0d", i, m), a, b, c,
                       model_mode(m, a, b, c));
        end

        // R7: back-to-back stream through bank A
        apply_mode(4);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i >= 3 && i < 7)
                check($sformatf("R7 stream pixel %0d", i - 3), {pix_valid_out, pix_out},
                      {1'b1, model(setA, 100*(i-3)+5, 3000-200*(i-3), 50*(i-3))});
            if (i == 7)
                check("R7 valid drops after stream", {36'd0, pix_valid_out}, 37'd0);
            if (i < 4) begin
                pix_valid_in = 1'b1;
                pix_in = {12'(50*i), 12'(3000-200*i), 12'(100*i+5)};
            end else begin
                pix_valid_in = 1'b0;
            end
        end

        // R5: write into the active bank and change mode_sel without a strobe
        write_word(1'b0, 0, {16'(0), 16'(8192)});
        push_check("R5 active bank write held", 800, 900, 1000, model(setA, 800, 900, 1000));
        @(negedge clk);
        mode_sel = 3'd5;
        push_check("R5 mode change without strobe", 800, 900, 1000, model(setA, 800, 900, 1000));
        setA[0] = 8192;
        setA[1] = 0;
        apply_mode(4);
        // R3: only word 0 of bank A differs after the strobe
        push_check("R3 R5 new bank A after strobe", 800, 900, 1000, model(setA, 800, 900, 1000));

        // R5: pixel in the strobe cycle uses the previous set
        @(negedge clk);
        mode_sel = 3'd5; frame_start = 1'b1;
        pix_valid_in = 1'b1; pix_in = {12'd7, 12'd2500, 12'd3};
        @(negedge clk);
        frame_start = 1'b0; pix_valid_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R5 strobe-cycle pixel uses old set", {pix_valid_out, pix_out},
              {1'b1, model(setA, 3, 2500, 7)});
        push_check("R5 pixel after strobe uses bank B", 3, 2500, 7, model(setB, 3, 2500, 7));

        // R2: words 6 and 7 are ignored
        write_word(1'b1, 6, 32'h1234_5678);
        write_word(1'b1, 7, 32'h8765_4321);
        apply_mode(5);
        push_check("R2 words 6 and 7 ignored", 4095, 100, 5, model(setB, 4095, 100, 5));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule